// File: doc/BRIEF.md
# Single-precision to extended-float converter

This block takes a 32-bit IEEE 754 single-precision word and produces the same value in a 48-bit extended float format. That format has a 24-bit two's-complement normalized fraction mantissa with no hidden bit, and a 14-bit exponent biased by 8191. The exponent sits zero-extended in a 24-bit word. The conversion restores the implied leading one and places the magnitude as a fraction 0.1f. It then rounds away one bit of precision, converts sign-magnitude to two's complement and rebiases the exponent. The special cases are fixed by rule. Zeros and denormals flush to the single zero. Infinities and NaNs saturate to the largest number of their sign and raise an exception flag.

An input word is presented with `valid_i` high for one cycle. One clock later `done_o` pulses for one cycle and the result appears on the output registers. The result holds there until the next accepted word. The block accepts a new word every cycle.

Top module: `f2x_conv`

## Requirements
- R1: A normal input (sign bit 31, biased exponent E in bits 30..23 with E from 1 to 254, fraction f in bits 22..0) gives an exponent word of E + 8065, which is E − 126 + 8191. A positive input gives mantissa {0, 1, upper 22 bits of f}, before rounding.
- R2: The dropped least significant fraction bit is rounded to nearest, ties to even. When f[0] is 1 and f[1] is 1, the kept magnitude is incremented. When f[0] is 1 and f[1] is 0, it is left unchanged.
- R3: If rounding carries the magnitude out to 1.0, the mantissa becomes 0x400000 and the exponent word increases by one.
- R4: A negative normal input gives the two's complement of the rounded magnitude. If that magnitude is exactly 0x400000, the output is mantissa 0x800000 with the exponent word decreased by one.
- R5: An input with E = 0 (both signed zeros and every denormal) gives mantissa 0x000000, exponent word 0x000000 and the exception flag low.
- R6: An input with E = 255 (infinities and NaNs) raises the exception flag. With sign 0 the output is mantissa 0x7FFFFF and exponent word 0x003FFF. With sign 1 it is mantissa 0x800000 and exponent word 0x003FFF.
- R7: Bits 23..14 of the exponent word are always zero. The mantissa output is never in 0x000001..0x3FFFFF or 0xC00000..0xFFFFFF.
- R8: `done_o` is high exactly in the cycle after a cycle with `valid_i` high. While `valid_i` is low, the input word is ignored and the outputs hold their values.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input word strobe |
| data_i | input | 32 | IEEE single-precision word |
| done_o | output | 1 | Result pulse, one cycle after valid_i |
| man_o | output | 24 | Two's-complement normalized mantissa |
| exp_o | output | 24 | Exponent word, 14-bit value biased by 8191 |
| exc_o | output | 1 | Infinity or NaN input was saturated |

## Verification
The bench targets the rounding tie cases, where a design that rounds half up instead of half to even is off by one LSB for even kept values. It covers the all-ones fraction, where a design that misses the carry emits a wrapped 0x000000 or an unnormalized mantissa. It covers −1.0 and negative inputs whose rounding carries to exactly 0.5. A design that negates naively there emits the illegal 0xC00000 with the wrong exponent. Signed zeros, denormals, infinities and NaN payloads are also driven. A design that decodes these wrongly leaks fraction bits, keeps a negative zero, or saturates to the wrong sign. Idle cycles with a changing input word expose outputs that do not hold.

// File: rtl/f2x_pkg.sv
package f2x_pkg;
  localparam int IN_EXP_W   = 8;
  localparam int IN_FRAC_W  = 23;
  localparam int OUT_MAN_W  = 24;
  localparam int OUT_EXP_W  = 14;
  localparam int OUT_WORD_W = 24;
  localparam int OUT_BIAS   = 8191;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_NORM    = 2'd1,
    CLS_SPECIAL = 2'd2
  } cls_e;
endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack
  import f2x_pkg::*;
#(
  parameter int EXP_W  = IN_EXP_W,
  parameter int FRAC_W = IN_FRAC_W,
  parameter int XW     = OUT_EXP_W,
  parameter int BIAS   = OUT_BIAS,
  localparam int IN_W  = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic [IN_W-1:0]  word_i,
  output logic             sign_o,
  output cls_e             cls_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [XW-1:0]    exp_o
);
  localparam int IN_BIAS = (1 << (EXP_W - 1)) - 1;
  // 1.f * 2^(E-ib) == 0.1f * 2^(E-ib+1)
  localparam logic [XW-1:0] OFFS = XW'(BIAS - IN_BIAS + 1);

  logic [EXP_W-1:0]  e_raw;
  logic [FRAC_W-1:0] f_raw;

  always_comb begin
    sign_o = word_i[IN_W-1];
    e_raw  = word_i[IN_W-2:FRAC_W];
    f_raw  = word_i[FRAC_W-1:0];
    sig_o  = {1'b1, f_raw};
    exp_o  = {{(XW-EXP_W){1'b0}}, e_raw} + OFFS;
    if (e_raw == '0)      cls_o = CLS_ZERO;
    else if (&e_raw)      cls_o = CLS_SPECIAL;
    else                  cls_o = CLS_NORM;
  end
endmodule

// File: rtl/f2x_round.sv
module f2x_round #(
  parameter int SIG_W = 24,
  parameter int MAG_W = 23,
  parameter int XW    = 14,
  localparam int DROP = SIG_W - MAG_W
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic [XW-1:0]    exp_i,
  output logic [MAG_W-1:0] mag_o,
  output logic [XW-1:0]    exp_o
);
  logic [MAG_W-1:0] kept;
  logic [DROP-1:0]  dropped;
  logic [DROP-1:0]  half;
  logic             rnd_up;
  logic [MAG_W:0]   sum;

  always_comb begin
    kept          = sig_i[SIG_W-1:DROP];
    dropped       = sig_i[DROP-1:0];
    half          = '0;
    half[DROP-1]  = 1'b1;
    rnd_up        = (dropped > half) || ((dropped == half) && kept[0]);
    sum           = {1'b0, kept} + {{MAG_W{1'b0}}, rnd_up};
    if (sum[MAG_W]) begin
      // carry to 1.0: renormalize to 0.5 with one more exponent step
      mag_o          = '0;
      mag_o[MAG_W-1] = 1'b1;
      exp_o          = exp_i + XW'(1);
    end else begin
      mag_o = sum[MAG_W-1:0];
      exp_o = exp_i;
    end
  end
endmodule

// File: rtl/f2x_pack.sv
module f2x_pack
  import f2x_pkg::*;
#(
  parameter int MAN_W  = OUT_MAN_W,
  parameter int XW     = OUT_EXP_W,
  parameter int WORD_W = OUT_WORD_W,
  localparam int MAG_W = MAN_W - 1
) (
  input  logic              sign_i,
  input  cls_e              cls_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [XW-1:0]     exp_i,
  output logic [MAN_W-1:0]  man_o,
  output logic [WORD_W-1:0] exp_o,
  output logic              exc_o
);
  logic [MAG_W-1:0] half_mag;
  logic [MAN_W-1:0] neg_one;
  logic [XW-1:0]    e_sel;

  always_comb begin
    half_mag            = '0;
    half_mag[MAG_W-1]   = 1'b1;
    neg_one             = '0;
    neg_one[MAN_W-1]    = 1'b1;
    man_o = '0;
    e_sel = '0;
    exc_o = 1'b0;
    unique case (cls_i)
      CLS_SPECIAL: begin
        man_o = sign_i ? neg_one : {1'b0, {MAG_W{1'b1}}};
        e_sel = '1;
        exc_o = 1'b1;
      end
      CLS_NORM: begin
        if (!sign_i) begin
          man_o = {1'b0, mag_i};
          e_sel = exp_i;
        end else if (mag_i == half_mag) begin
          // -0.5 is not normalized; -1.0 at one lower exponent is
          man_o = neg_one;
          e_sel = exp_i - XW'(1);
        end else begin
          man_o = -{1'b0, mag_i};
          e_sel = exp_i;
        end
      end
      default: begin
        man_o = '0;
        e_sel = '0;
      end
    endcase
    exp_o = {{(WORD_W-XW){1'b0}}, e_sel};
  end
endmodule

// File: rtl/f2x_conv.sv
module f2x_conv
  import f2x_pkg::*;
#(
  parameter int EXP_W  = IN_EXP_W,
  parameter int FRAC_W = IN_FRAC_W,
  parameter int MAN_W  = OUT_MAN_W,
  parameter int XW     = OUT_EXP_W,
  parameter int WORD_W = OUT_WORD_W,
  parameter int BIAS   = OUT_BIAS,
  localparam int IN_W  = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int MAG_W = MAN_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   data_i,
  output logic              done_o,
  output logic [MAN_W-1:0]  man_o,
  output logic [WORD_W-1:0] exp_o,
  output logic              exc_o
);
  logic             sign;
  cls_e             cls;
  logic [SIG_W-1:0] sig;
  logic [XW-1:0]    exp_raw;
  logic [MAG_W-1:0] mag;
  logic [XW-1:0]    exp_rnd;
  logic [MAN_W-1:0]  man_d;
  logic [WORD_W-1:0] exp_d;
  logic              exc_d;

  f2x_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW), .BIAS(BIAS)) u_unpack (
    .word_i(data_i), .sign_o(sign), .cls_o(cls), .sig_o(sig), .exp_o(exp_raw)
  );

  f2x_round #(.SIG_W(SIG_W), .MAG_W(MAG_W), .XW(XW)) u_round (
    .sig_i(sig), .exp_i(exp_raw), .mag_o(mag), .exp_o(exp_rnd)
  );

  f2x_pack #(.MAN_W(MAN_W), .XW(XW), .WORD_W(WORD_W)) u_pack (
    .sign_i(sign), .cls_i(cls), .mag_i(mag), .exp_i(exp_rnd),
    .man_o(man_d), .exp_o(exp_d), .exc_o(exc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      man_o  <= '0;
      exp_o  <= '0;
      exc_o  <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        man_o <= man_d;
        exp_o <= exp_d;
        exc_o <= exc_d;
      end
    end
  end

  p_done_after_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_done_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));
  p_hold_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(man_o) && $stable(exp_o) && $stable(exc_o)));
  p_exp_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o[WORD_W-1:XW] == '0);
  p_man_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_o == '0) || (man_o[MAN_W-1] != man_o[MAN_W-2]));
  p_zero_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_o == '0) |-> (exp_o == '0 && !exc_o));
  p_exc_saturates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (&exp_o[XW-1:0]));
endmodule

// File: tb/f2x_conv_tb.sv
module f2x_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] data = '0;
  logic        done;
  logic [23:0] man;
  logic [23:0] expw;
  logic        exc;

  int n_chk = 0;
  int n_bad = 0;
  bit run_chk = 1'b0;

  always #10 clk = ~clk;

  f2x_conv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .done_o(done), .man_o(man), .exp_o(expw), .exc_o(exc)
  );

  task automatic ref_model(input logic [31:0] w, output logic [23:0] m,
                           output logic [23:0] x, output logic ex, output string tag);
    int e, f, sig, mag, xe;
    e = int'(w[30:23]);
    f = int'(w[22:0]);
    ex = 1'b0;
    if (e == 0) begin
      m = 24'h0; x = 24'h0; tag = "R5";
    end else if (e == 255) begin
      m = w[31] ? 24'h800000 : 24'h7FFFFF; x = 24'h003FFF; ex = 1'b1; tag = "R6";
    end else begin
      tag = "R1";
      sig = (1 << 23) | f;
      mag = sig / 2;
      if ((sig % 2) == 1) begin
        tag = "R2";
        if ((mag % 2) == 1) mag = mag + 1;
      end
      xe = e - 126 + 8191;
      if (mag == (1 << 23)) begin
        mag = 1 << 22; xe = xe + 1; tag = "R3";
      end
      if (w[31]) begin
        tag = {tag, "/R4"};
        if (mag == (1 << 22)) begin
          m = 24'h800000; xe = xe - 1;
        end else begin
          m = 24'((1 << 24) - mag);
        end
      end else begin
        m = 24'(mag);
      end
      x = 24'(xe);
    end
  endtask

  logic        m_done;
  logic [23:0] m_man, m_exp;
  logic        m_exc;
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done <= 1'b0; m_man <= '0; m_exp <= '0; m_exc <= 1'b0; m_tag <= "R9";
    end else begin
      m_done <= valid;
      if (valid) begin
        logic [23:0] tm, tx; logic te; string tt;
        ref_model(data, tm, tx, te, tt);
        m_man <= tm; m_exp <= tx; m_exc <= te; m_tag <= tt;
      end else begin
        m_tag <= "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      n_chk++;
      if (done !== m_done || man !== m_man || expw !== m_exp || exc !== m_exc) begin
        n_bad++;
        $display("FAIL %s: got done=%b man=%h exp=%h exc=%b, want done=%b man=%h exp=%h exc=%b",
                 m_tag, done, man, expw, exc, m_done, m_man, m_exp, m_exc);
      end
    end
  end

  task automatic drive(input logic [31:0] w, input logic v);
    @(negedge clk);
    valid = v;
    data  = w;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if (done !== 1'b0 || man !== 24'h0 || expw !== 24'h0 || exc !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: got done=%b man=%h exp=%h exc=%b, want all zero", done, man, expw, exc);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run_chk = 1'b1;
    drive(32'h3F800000, 1);  // R1 1.0
    drive(32'h3FC00000, 1);  // R1 1.5
    drive(32'hBFC00000, 1);  // R4 -1.5
    drive(32'hBF800000, 1);  // R4 -1.0 half corner
    drive(32'h3F800001, 1);  // R2 tie, kept even
    drive(32'h3F800003, 1);  // R2 tie, kept odd
    drive(32'h3FFFFFFF, 1);  // R3 carry
    drive(32'hBFFFFFFF, 1);  // R3/R4 carry then half corner
    drive(32'h7F7FFFFF, 1);  // R3 max normal
    drive(32'h00800000, 1);  // R1 min normal
    drive(32'h80800000, 1);  // R4 min normal negative
    drive(32'h00000000, 1);  // R5 +0
    drive(32'h80000000, 1);  // R5 -0
    drive(32'h00000001, 1);  // R5 denormal
    drive(32'h807FFFFF, 1);  // R5 negative denormal
    drive(32'h7F800000, 1);  // R6 +inf
    drive(32'hFF800000, 1);  // R6 -inf
    drive(32'h7FC00000, 1);  // R6 NaN
    drive(32'hFFFFFFFF, 1);  // R6 negative NaN
    drive(32'h3F800000, 1);
    drive(32'h12345678, 0);  // R8 ignored while idle
    drive(32'h7F800000, 0);  // R8 ignored while idle
    drive(32'hBF800000, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      int sel;
      w = $urandom;
      sel = $urandom_range(0, 9);
      if (sel == 0) w[30:23] = 8'h00;
      else if (sel == 1) w[30:23] = 8'hFF;
      else if (sel == 2) w[22:0] = 23'h7FFFFF;
      else if (sel == 3) w[22:0] = 23'h000001;
      drive(w, ($urandom_range(0, 3) != 0));
    end
    drive(32'h0, 0);
    drive(32'h0, 0);
    @(negedge clk);
    run_chk = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout, want completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule